// File: doc/BRIEF.md
# Register Pair Stack Unit

This block holds the working registers of a small 8-bit processor: six general byte registers that combine into three fixed 16-bit pairs, an accumulator, a flag byte and a 16-bit stack pointer. Its main job is to move one register pair to or from a stack kept in a byte-wide memory. A request names the direction (save or restore) and a 2-bit pair code. The unit then runs the two byte accesses on its memory port and reports completion with a single-cycle pulse.

The stack lives at descending addresses. A save lowers the pointer before each store: the upper byte goes in first and the lower byte second. A restore does the same steps in reverse. It reads the lower byte at the pointer and then the upper byte at the next address, raising the pointer after each read. Pair code 3 names the accumulator (upper byte) together with the flag byte (lower byte). Any byte register can also be read and written at any time through a plain index port. The memory answers reads combinationally in the same cycle as the address and takes writes at the clock edge. One access therefore fits in one cycle.

Top module: `regpair_stack_unit`

## Requirements
- R1: When `rst_n` is low at a clock edge, the stack pointer becomes 0x0000, all eight byte registers become 0x00, and `done`, `mem_we` and `mem_re` are 0 in the following cycle.
- R2: The register port uses index 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=flags, 7=accumulator. `reg_rdata` shows the indexed register combinationally. A write with `reg_we` high takes effect at the clock edge.
- R3: Pair code 0 selects B (upper) with C (lower). Code 1 selects D with E, code 2 selects H with L, and code 3 selects the accumulator (upper) with the flag byte (lower).
- R4: A save accepted at edge k drives `mem_we`=1 in the cycle after k, at address SP-1 with the upper byte. In the next cycle it drives `mem_we`=1 at address SP-2 with the lower byte. The pointer ends at SP-2.
- R5: A restore accepted at edge k drives `mem_re`=1 in the cycle after k, at address SP, and loads the read byte into the lower register. In the next cycle it reads address SP+1 into the upper register. The pointer ends at SP+2.
- R6: Every write into the flag byte, from a restore or from the register port, stores bits 5 and 3 as 0 and bit 1 as 1. The other bits (7 sign, 6 zero, 4 half-carry, 2 parity, 0 carry) are stored as given.
- R7: `done` is 1 for exactly one cycle, the cycle after the second memory access, and the pointer output already holds its final value in that cycle.
- R8: A `start` raised while a sequence is running is ignored. The running sequence completes unchanged and no second sequence follows.
- R9: Stack pointer arithmetic wraps modulo 2^16 (0x0000 minus 1 is 0xFFFF, 0xFFFF plus 1 is 0x0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a save or restore when idle |
| op_pop | input | 1 | 1 = restore from stack, 0 = save to stack |
| pair_sel | input | 2 | Pair code (see R3) |
| reg_we | input | 1 | Register port write enable |
| reg_widx | input | 3 | Register port write index |
| reg_wdata | input | 8 | Register port write data |
| reg_ridx | input | 3 | Register port read index |
| reg_rdata | output | 8 | Register port read data |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read strobe; data captured this cycle |
| mem_rdata | input | 8 | Memory read data, valid in the cycle of `mem_re` |
| done | output | 1 | One-cycle completion pulse |
| stack_ptr | output | 16 | Current stack pointer |

## Verification
The assertions check on every cycle that reads and writes never overlap and that the two stores of a save step one address downward. They also check that the two reads of a restore step one address upward, that `done` lasts one cycle and always follows an access, that the final pointer agrees with the last address used, and that reset clears the pointer. Only the bench scenarios can show the data side. That covers which register lands in which byte for each pair code, the forcing of flag bits, the pointer wrap across 0x0000, and a second request being dropped while a sequence runs.

// File: rtl/rps_pkg.sv
// Shared constants, types and pair decoding for the register pair stack unit.
// Assumes byte registers and a byte-addressed 16-bit memory space.
package rps_pkg;
    localparam int REG_W    = 8;
    localparam int ADDR_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [IDX_W-1:0] IDX_FLAGS = IDX_W'(6);
    localparam logic [IDX_W-1:0] IDX_ACC   = IDX_W'(7);

    // Flag bits 5 and 3 are held low, bit 1 is held high.
    localparam logic [REG_W-1:0] FLAG_KEEP = 8'hD5;
    localparam logic [REG_W-1:0] FLAG_SET  = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_t;

    // Upper register of a pair; code 3 selects the accumulator.
    function automatic logic [IDX_W-1:0] pair_hi_idx(input logic [1:0] code);
        return (code == 2'd3) ? IDX_ACC : {code, 1'b0};
    endfunction

    // Lower register of a pair; code 3 selects the flag byte.
    function automatic logic [IDX_W-1:0] pair_lo_idx(input logic [1:0] code);
        return (code == 2'd3) ? IDX_FLAGS : {code, 1'b1};
    endfunction
endpackage

// File: rtl/rps_flag_filter.sv
// Forces the fixed bits of the flag byte on any value about to be stored.
// Purely combinational; assumes the fixed-bit masks from rps_pkg.
module rps_flag_filter
    import rps_pkg::*;
(
    input  logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] clean
);
    // Clear the held-low bits, then set the held-high bit.
    always_comb clean = (raw & FLAG_KEEP) | FLAG_SET;
endmodule

// File: rtl/rps_regfile.sv
// Byte register file with one host write, one sequencer write, one host read
// and one pair read. The sequencer write wins when both target one register.
// The flag register gets the fixed-bit filter on its input.
module rps_regfile
    import rps_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = NUM_REGS,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [IW-1:0] host_widx,
    input  logic [W-1:0]  host_wdata,
    input  logic          seq_we,
    input  logic [IW-1:0] seq_idx,
    input  logic [W-1:0]  seq_wdata,
    input  logic [IW-1:0] host_ridx,
    output logic [W-1:0]  host_rdata,
    input  logic [1:0]    pair_code,
    output logic [W-1:0]  pair_hi,
    output logic [W-1:0]  pair_lo
);
    logic [W-1:0] view [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic         hit_seq;
        logic         hit_host;
        logic [W-1:0] next_raw;
        logic [W-1:0] next_val;
        logic [W-1:0] q;

        // Pick the winning write source for this register.
        always_comb begin
            hit_seq  = seq_we  && (seq_idx   == IW'(g));
            hit_host = host_we && (host_widx == IW'(g));
            next_raw = hit_seq ? seq_wdata : host_wdata;
        end

        if (g == int'(IDX_FLAGS)) begin : g_flags
            rps_flag_filter i_filter (.raw(next_raw), .clean(next_val));
        end else begin : g_plain
            assign next_val = next_raw;
        end

        // Hold the register, clear on reset, load on a write hit.
        always_ff @(posedge clk) begin
            if (!rst_n)                    q <= '0;
            else if (hit_seq || hit_host)  q <= next_val;
        end

        assign view[g] = q;
    end

    // Read ports.
    always_comb begin
        host_rdata = view[host_ridx];
        pair_hi    = view[pair_hi_idx(pair_code)];
        pair_lo    = view[pair_lo_idx(pair_code)];
    end
endmodule

// File: rtl/rps_stack_seq.sv
// Runs the two-byte save/restore sequence and owns the stack pointer.
// Assumes memory reads return data in the same cycle as the address.
module rps_stack_seq
    import rps_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W,
    localparam int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_pop,
    input  logic [1:0]    pair_sel,
    input  logic [W-1:0]  pair_hi,
    input  logic [W-1:0]  pair_lo,
    input  logic [W-1:0]  mem_rdata,
    output logic [1:0]    pair_code,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic          seq_we,
    output logic [IW-1:0] seq_idx,
    output logic [W-1:0]  seq_wdata,
    output logic          done,
    output logic [AW-1:0] stack_ptr
);
    seq_state_t    state;
    logic          pop_q;
    logic [1:0]    pair_q;
    logic [AW-1:0] sp_q;
    logic          done_q;
    logic          active;

    // Decode the memory side and register loads from the current step.
    always_comb begin
        active    = (state != ST_IDLE);
        mem_we    = active && !pop_q;
        mem_re    = active && pop_q;
        mem_addr  = mem_we ? (sp_q - AW'(1)) : sp_q;
        mem_wdata = !mem_we ? '0 : ((state == ST_FIRST) ? pair_hi : pair_lo);
        seq_we    = mem_re;
        seq_idx   = (state == ST_FIRST) ? pair_lo_idx(pair_q) : pair_hi_idx(pair_q);
        seq_wdata = mem_rdata;
        pair_code = pair_q;
        done      = done_q;
        stack_ptr = sp_q;
    end

    // Step the sequence, move the pointer and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pop_q  <= 1'b0;
            pair_q <= 2'd0;
            sp_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state == ST_SECOND);
            unique case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_FIRST;
                    pop_q  <= op_pop;
                    pair_q <= pair_sel;
                end
                ST_FIRST:  state <= ST_SECOND;
                ST_SECOND: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
            if (active) sp_q <= pop_q ? (sp_q + AW'(1)) : (sp_q - AW'(1));
        end
    end
endmodule

// File: rtl/regpair_stack_unit.sv
// Top of the register pair stack unit: register file plus stack sequencer.
// Assumes a byte memory with same-cycle read data and edge-timed writes.
module regpair_stack_unit
    import rps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_pop,
    input  logic [1:0]        pair_sel,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_widx,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [IDX_W-1:0]  reg_ridx,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REG_W-1:0]  mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [REG_W-1:0]  mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] stack_ptr
);
    logic [1:0]       pair_code;
    logic [REG_W-1:0] pair_hi;
    logic [REG_W-1:0] pair_lo;
    logic             seq_we;
    logic [IDX_W-1:0] seq_idx;
    logic [REG_W-1:0] seq_wdata;

    rps_regfile i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (reg_we),
        .host_widx  (reg_widx),
        .host_wdata (reg_wdata),
        .seq_we     (seq_we),
        .seq_idx    (seq_idx),
        .seq_wdata  (seq_wdata),
        .host_ridx  (reg_ridx),
        .host_rdata (reg_rdata),
        .pair_code  (pair_code),
        .pair_hi    (pair_hi),
        .pair_lo    (pair_lo)
    );

    rps_stack_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_pop    (op_pop),
        .pair_sel  (pair_sel),
        .pair_hi   (pair_hi),
        .pair_lo   (pair_lo),
        .mem_rdata (mem_rdata),
        .pair_code (pair_code),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .seq_we    (seq_we),
        .seq_idx   (seq_idx),
        .seq_wdata (seq_wdata),
        .done      (done),
        .stack_ptr (stack_ptr)
    );
endmodule

// File: rtl/regpair_stack_unit_chk.sv
// Protocol checker for regpair_stack_unit, attached by bind below.
// Observes only the top-level ports.
module regpair_stack_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic        done,
    input logic [15:0] stack_ptr
);
    // R1: reset leaves the pointer at zero and the port quiet.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (stack_ptr == 16'h0000 && !done && !mem_we && !mem_re));

    // R4/R5: a cycle never both reads and writes.
    a_r5_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4: back-to-back stores step one address down.
    a_r4_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(rst_n)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    // R5: back-to-back reads step one address up.
    a_r5_pop_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re) && $past(rst_n)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R7: completion pulse lasts one cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: completion pulse directly follows a memory access.
    a_r7_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_we) || $past(mem_re)));

    // R4: after a save the pointer equals the lower byte's address.
    a_r4_sp_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mem_we)) |-> (stack_ptr == $past(mem_addr)));

    // R5: after a restore the pointer is one past the upper byte's address.
    a_r5_sp_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mem_re)) |-> (stack_ptr == $past(mem_addr) + 16'd1));
endmodule

bind regpair_stack_unit regpair_stack_unit_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .done      (done),
    .stack_ptr (stack_ptr)
);

// File: tb/test_regpair_stack_unit.sv
// Directed bench for regpair_stack_unit with a 256-byte memory model.
module test_regpair_stack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_pop = 1'b0;
    logic [1:0]  pair_sel = 2'd0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_widx = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [2:0]  reg_ridx = 3'd0;
    logic [7:0]  reg_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [15:0] stack_ptr;

    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = 8'd0;
    logic [7:0]  poke_data = 8'd0;
    logic [7:0]  bmem [256];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    regpair_stack_unit i_regpair_stack_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_pop(op_pop), .pair_sel(pair_sel),
        .reg_we(reg_we), .reg_widx(reg_widx), .reg_wdata(reg_wdata),
        .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .done(done), .stack_ptr(stack_ptr)
    );

    // Memory model: same-cycle read, edge write, bench poke port.
    assign mem_rdata = bmem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (mem_we)  bmem[mem_addr[7:0]] <= mem_wdata;
        if (poke_en) bmem[poke_addr]     <= poke_data;
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_widx = idx; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] idx, output logic [7:0] val);
        reg_ridx = idx;
        #1 val = reg_rdata;
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // Issue a request; returns at the negedge inside the first access cycle.
    task automatic launch(input logic pop, input logic [1:0] pair);
        @(negedge clk);
        start = 1'b1; op_pop = pop; pair_sel = pair;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Check a full save sequence of pair p, starting pointer sp0.
    task automatic run_push(input string req, input logic [1:0] p, input logic [15:0] sp0,
                            input logic [7:0] hi, input logic [7:0] lo);
        launch(1'b0, p);
        chk(req, "push1 we", {15'd0, mem_we}, 16'd1);
        chk(req, "push1 addr", mem_addr, sp0 - 16'd1);
        chk(req, "push1 data", {8'd0, mem_wdata}, {8'd0, hi});
        @(negedge clk);
        chk(req, "push2 we", {15'd0, mem_we}, 16'd1);
        chk(req, "push2 addr", mem_addr, sp0 - 16'd2);
        chk(req, "push2 data", {8'd0, mem_wdata}, {8'd0, lo});
        @(negedge clk);
        chk("R7", "push done", {15'd0, done}, 16'd1);
        chk(req, "push sp", stack_ptr, sp0 - 16'd2);
        @(negedge clk);
        chk("R7", "push done drop", {15'd0, done}, 16'd0);
    endtask

    // Check a full restore sequence, starting pointer sp0.
    task automatic run_pop(input string req, input logic [1:0] p, input logic [15:0] sp0);
        launch(1'b1, p);
        chk(req, "pop1 re", {15'd0, mem_re}, 16'd1);
        chk(req, "pop1 addr", mem_addr, sp0);
        @(negedge clk);
        chk(req, "pop2 re", {15'd0, mem_re}, 16'd1);
        chk(req, "pop2 addr", mem_addr, sp0 + 16'd1);
        @(negedge clk);
        chk("R7", "pop done", {15'd0, done}, 16'd1);
        chk(req, "pop sp", stack_ptr, sp0 + 16'd2);
        @(negedge clk);
        chk("R7", "pop done drop", {15'd0, done}, 16'd0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1", "sp", stack_ptr, 16'h0000);
        chk("R1", "done", {15'd0, done}, 16'd0);
        chk("R1", "we/re", {14'd0, mem_we, mem_re}, 16'd0);
        for (int i = 0; i < 8; i++) begin
            rd_reg(3'(i), v);
            chk("R1", "reg clear", {8'd0, v}, 16'd0);
        end
    endtask

    task automatic t_regport;
        logic [7:0] v;
        logic [7:0] vals [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'hFF, 8'h77};
        for (int i = 0; i < 8; i++) wr_reg(3'(i), vals[i]);
        for (int i = 0; i < 6; i++) begin
            rd_reg(3'(i), v);
            chk("R2", "reg readback", {8'd0, v}, {8'd0, vals[i]});
        end
        rd_reg(3'd7, v);
        chk("R2", "acc readback", {8'd0, v}, 16'h0077);
        rd_reg(3'd6, v);
        chk("R6", "flags from FF", {8'd0, v}, 16'h00D7);
        wr_reg(3'd6, 8'h00);
        rd_reg(3'd6, v);
        chk("R6", "flags from 00", {8'd0, v}, 16'h0002);
        wr_reg(3'd6, 8'hFF);
    endtask

    task automatic t_push_wrap;
        // Pair code 0 = B:C from pointer 0x0000, wraps to 0xFFFF (R9).
        run_push("R4", 2'd0, 16'h0000, 8'h11, 8'h22);
        chk("R9", "wrap down", stack_ptr, 16'hFFFE);
        // Pair code 3 = accumulator:flags.
        run_push("R3", 2'd3, 16'hFFFE, 8'h77, 8'hD7);
    endtask

    task automatic t_pop_de;
        logic [7:0] v;
        run_pop("R5", 2'd1, 16'hFFFC);
        rd_reg(3'd3, v);
        chk("R5", "E gets low byte", {8'd0, v}, 16'h00D7);
        rd_reg(3'd2, v);
        chk("R3", "D gets high byte", {8'd0, v}, 16'h0077);
    endtask

    task automatic t_pop_psw;
        logic [7:0] v;
        poke(8'hFE, 8'h28);
        poke(8'hFF, 8'h9C);
        run_pop("R5", 2'd3, 16'hFFFE);
        chk("R9", "wrap up", stack_ptr, 16'h0000);
        rd_reg(3'd6, v);
        chk("R6", "popped flags", {8'd0, v}, 16'h0002);
        rd_reg(3'd7, v);
        chk("R3", "popped acc", {8'd0, v}, 16'h009C);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v;
        // H=55, L=66 saved; a restore request in mid-sequence must be dropped.
        launch(1'b0, 2'd2);
        start = 1'b1; op_pop = 1'b1; pair_sel = 2'd0;
        chk("R8", "first stays save", {15'd0, mem_we}, 16'd1);
        chk("R8", "first addr", mem_addr, 16'hFFFF);
        @(negedge clk);
        start = 1'b0;
        chk("R8", "second stays save", {14'd0, mem_we, mem_re}, 16'd2);
        chk("R8", "second addr", mem_addr, 16'hFFFE);
        chk("R3", "L stored", {8'd0, mem_wdata}, 16'h0066);
        @(negedge clk);
        chk("R8", "done", {15'd0, done}, 16'd1);
        chk("R8", "sp", stack_ptr, 16'hFFFE);
        @(negedge clk);
        chk("R8", "no follow-on", {14'd0, mem_we, mem_re}, 16'd0);
        @(negedge clk);
        chk("R8", "still idle", {13'd0, mem_we, mem_re, done}, 16'd0);
        rd_reg(3'd1, v);
        chk("R8", "C untouched", {8'd0, v}, 16'h0022);
        // Round trip: clear H/L, restore them.
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd5, 8'h00);
        run_pop("R5", 2'd2, 16'hFFFE);
        rd_reg(3'd4, v);
        chk("R3", "H restored", {8'd0, v}, 16'h0055);
        rd_reg(3'd5, v);
        chk("R3", "L restored", {8'd0, v}, 16'h0066);
    endtask

    task automatic t_reset_again;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regport();
        t_push_wrap();
        t_pop_de();
        t_pop_psw();
        t_busy_ignore();
        t_reset_again();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule